// File: doc/BRIEF.md
# Serial Shift-Add Mantissa Multiplier

This block forms the product of two normalized fixed-point mantissas, one bit step per clock. Each mantissa is `WORD_W*N_WORDS` bits wide. Its integer bit sits at position `INT_POS`, and its lowest `GUARD` bits are zero. On a start pulse the block latches the multiplicand, the multiplier and an exponent sum. It then walks the multiplier from its least significant end. On each bit step the accumulator moves right by one bit, and the multiplicand is added when the current multiplier bit is 1. Every bit that falls off the bottom of the accumulator is OR-ed into a sticky flag.

The multiplier is handled in `WORD_W`-bit words. A word found to be all zero at its start costs only one cycle. For the lowest word that cycle does no shift, because the accumulator is still empty. For a higher word it is a single `WORD_W`-bit shift. The scan ends right after the top set bit of the multiplier. One further cycle renormalizes a product of 2 or more and produces the result. A floating-point datapath uses the block as its multiply core; rounding and special operands are handled around it.

Operand contract: both mantissas have bit `INT_POS` set, nothing above it, and zero guard bits. `INT_POS` lies in the top word.

Top module: `serial_mant_mul`

## Requirements
- R1: While and directly after reset, `done_o`, `prod_o`, `exp_o` and `sticky_o` are all zero.
- R2: With P = X*Y, the result depends on whether P < 2^(2*INT_POS+1). In that case `prod_o` = floor(P / 2^INT_POS), `sticky_o` is 1 exactly when P mod 2^INT_POS is nonzero, and `exp_o` equals the latched `exp_i`.
- R3: When P >= 2^(2*INT_POS+1), `prod_o` = floor(P / 2^(INT_POS+1)), `sticky_o` is 1 exactly when P mod 2^(INT_POS+1) is nonzero, and `exp_o` = `exp_i` + 1 (modulo 2^EXP_W).
- R4: `done_o` rises after the edge that accepts start plus L+1 further edges. L is the sum of a per-word scan cost over all words; the cost of the top word is INT_POS - (N_WORDS-1)*WORD_W + 1.
- R5: The lowest multiplier word costs WORD_W-GUARD cycles when nonzero and 1 cycle when zero.
- R6: Every other word below the top costs WORD_W cycles when nonzero and 1 cycle when all zero.
- R7: `done_o` is high for exactly one cycle per product. The result outputs keep their values until the next `done_o`.
- R8: A start pulse arriving while a product is in progress is ignored. This holds even when the operand inputs change along with it: result and timing equal those of the original operands.
- R9: The carry out of each accumulate is kept, so operands with every usable bit set (product just under 4) give an exact R3 result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a product; sampled only when idle |
| mcand_i | input | WORD_W*N_WORDS | Multiplicand mantissa |
| mplier_i | input | WORD_W*N_WORDS | Multiplier mantissa, scanned from bit 0 upward |
| exp_i | input | EXP_W | Sum of the operand exponents |
| done_o | output | 1 | One-cycle pulse: result outputs are new |
| prod_o | output | WORD_W*N_WORDS | Normalized product mantissa, integer bit at INT_POS |
| exp_o | output | EXP_W | Exponent after the renormalizing adjustment |
| sticky_o | output | 1 | OR of every bit dropped below the product |

## Verification
The hardest case to reach from the ports is a renormalization whose extra shifted-out bit is the only thing that sets sticky, or a carry that is present only in the last accumulate. Both depend on exact operand values, not on the word layout. The stimulus therefore uses hand-built mantissas: all usable bits set, exactly 1.5 times 1.5, and multipliers with chosen zero words. These land on both sides of the product-of-two boundary and on every word-skip path. Busy-time start pulses carry different operands, so a leak shows up in the result as well as in the timing.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_NORM
  } smul_state_t;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_STEP,
    OP_SKIP,
    OP_SKIP0
  } smul_op_t;

endpackage

// File: rtl/smul_yreg.sv
module smul_yreg
  import smul_pkg::*;
#(
  parameter int MW     = 128,
  parameter int WORD_W = 32,
  parameter int GUARD  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  smul_op_t      op,
  input  logic [MW-1:0] mplier,
  output logic          cur_bit,
  output logic          zero_lo,
  output logic          zero_full,
  output logic          more,
  output logic          empty
);

  logic [MW-1:0] ysh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ysh_q <= '0;
    end else begin
      case (op)
        OP_LOAD:  ysh_q <= mplier >> GUARD;
        OP_STEP:  ysh_q <= ysh_q >> 1;
        OP_SKIP:  ysh_q <= ysh_q >> WORD_W;
        OP_SKIP0: ysh_q <= ysh_q >> (WORD_W - GUARD);
        default:  ysh_q <= ysh_q;
      endcase
    end
  end

  assign cur_bit   = ysh_q[0];
  assign zero_lo   = (ysh_q[WORD_W-GUARD-1:0] == '0);
  assign zero_full = (ysh_q[WORD_W-1:0] == '0);
  assign more      = |ysh_q[MW-1:1];
  assign empty     = (ysh_q == '0);

endmodule

// File: rtl/smul_accum.sv
module smul_accum
  import smul_pkg::*;
#(
  parameter int MW      = 128,
  parameter int WORD_W  = 32,
  parameter int INT_POS = 114
) (
  input  logic          clk,
  input  logic          rst,
  input  smul_op_t      op,
  input  logic [MW-1:0] mcand,
  input  logic          cur_bit,
  output logic [MW-1:0] norm_mant,
  output logic          norm_stk,
  output logic          norm_inc
);

  localparam int ACC_W = MW + 1;

  logic [MW-1:0]    x_q;
  logic [ACC_W-1:0] acc_q;
  logic             stk_q;
  logic [ACC_W-1:0] step_sum;

  assign step_sum = {1'b0, acc_q[ACC_W-1:1]} + (cur_bit ? ACC_W'(x_q) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      acc_q <= '0;
      stk_q <= 1'b0;
    end else begin
      case (op)
        OP_LOAD: begin
          x_q   <= mcand;
          acc_q <= '0;
          stk_q <= 1'b0;
        end
        OP_STEP: begin
          acc_q <= step_sum;
          stk_q <= stk_q | acc_q[0];
        end
        OP_SKIP: begin
          acc_q <= acc_q >> WORD_W;
          stk_q <= stk_q | (|acc_q[WORD_W-1:0]);
        end
        default: ;
      endcase
    end
  end

  assign norm_inc  = |acc_q[ACC_W-1:INT_POS+1];
  assign norm_mant = norm_inc ? acc_q[MW:1] : acc_q[MW-1:0];
  assign norm_stk  = stk_q | (norm_inc & acc_q[0]);

endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 32,
  parameter int GUARD   = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     zero_lo,
  input  logic     zero_full,
  input  logic     more,
  input  logic     empty,
  output smul_op_t op,
  output logic     busy,
  output logic     fin
);

  localparam int WI_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int BI_W = $clog2(WORD_W);

  smul_state_t     st_q;
  logic [WI_W-1:0] widx_q;
  logic [BI_W-1:0] bidx_q;
  logic            first_q;
  logic            word_zero;

  assign word_zero = (widx_q == '0) ? zero_lo : zero_full;

  always_comb begin
    op  = OP_HOLD;
    fin = 1'b0;
    case (st_q)
      ST_IDLE: if (start) op = OP_LOAD;
      ST_SCAN: begin
        if (empty)                  op = OP_HOLD;
        else if (first_q && word_zero)
          op = (widx_q == '0) ? OP_SKIP0 : OP_SKIP;
        else                        op = OP_STEP;
      end
      ST_NORM: fin = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      widx_q  <= '0;
      bidx_q  <= '0;
      first_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_SCAN;
          widx_q  <= '0;
          bidx_q  <= BI_W'(GUARD);
          first_q <= 1'b1;
        end
        ST_SCAN: begin
          case (op)
            OP_SKIP, OP_SKIP0: begin
              widx_q  <= widx_q + 1'b1;
              bidx_q  <= '0;
              first_q <= 1'b1;
            end
            OP_STEP: begin
              if (!more) st_q <= ST_NORM;
              if (bidx_q == BI_W'(WORD_W - 1)) begin
                widx_q  <= widx_q + 1'b1;
                bidx_q  <= '0;
                first_q <= 1'b1;
              end else begin
                bidx_q  <= bidx_q + 1'b1;
                first_q <= 1'b0;
              end
            end
            default: st_q <= ST_NORM;
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/serial_mant_mul.sv
module serial_mant_mul
  import smul_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int GUARD   = 2,
  parameter int INT_POS = 114,
  parameter int EXP_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [WORD_W*N_WORDS-1:0] mcand_i,
  input  logic [WORD_W*N_WORDS-1:0] mplier_i,
  input  logic [EXP_W-1:0]          exp_i,
  output logic                      done_o,
  output logic [WORD_W*N_WORDS-1:0] prod_o,
  output logic [EXP_W-1:0]          exp_o,
  output logic                      sticky_o
);

  localparam int MW = WORD_W * N_WORDS;

  smul_op_t       op;
  logic           busy, fin;
  logic           cur_bit, zero_lo, zero_full, more, empty;
  logic [MW-1:0]  norm_mant;
  logic           norm_stk, norm_inc;
  logic [EXP_W-1:0] exp_q;

  smul_ctrl #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .GUARD(GUARD)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i),
    .zero_lo(zero_lo), .zero_full(zero_full), .more(more), .empty(empty),
    .op(op), .busy(busy), .fin(fin)
  );

  smul_yreg #(.MW(MW), .WORD_W(WORD_W), .GUARD(GUARD)) u_yreg (
    .clk(clk), .rst(rst), .op(op), .mplier(mplier_i),
    .cur_bit(cur_bit), .zero_lo(zero_lo), .zero_full(zero_full),
    .more(more), .empty(empty)
  );

  smul_accum #(.MW(MW), .WORD_W(WORD_W), .INT_POS(INT_POS)) u_acc (
    .clk(clk), .rst(rst), .op(op), .mcand(mcand_i), .cur_bit(cur_bit),
    .norm_mant(norm_mant), .norm_stk(norm_stk), .norm_inc(norm_inc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q    <= '0;
      done_o   <= 1'b0;
      prod_o   <= '0;
      exp_o    <= '0;
      sticky_o <= 1'b0;
    end else begin
      if (op == OP_LOAD) exp_q <= exp_i;
      done_o <= fin;
      if (fin) begin
        prod_o   <= norm_mant;
        sticky_o <= norm_stk;
        exp_o    <= exp_q + EXP_W'(norm_inc);
      end
    end
  end

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int GUARD   = 2,
  parameter int INT_POS = 114,
  parameter int EXP_W   = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      busy,
  input logic                      done_o,
  input logic [WORD_W*N_WORDS-1:0] prod_o,
  input logic [EXP_W-1:0]          exp_o,
  input logic                      sticky_o
);

  localparam int MAX_CYC = (WORD_W - GUARD) + WORD_W * (N_WORDS - 2)
                         + (INT_POS - (N_WORDS - 1) * WORD_W + 1) + 2;

  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  // R4: the scan never runs past its worst-case length
  p_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt < 16'(MAX_CYC)));

  // R4: a result only follows a busy period
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy));

  // R7: single-cycle completion pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: results hold between completions
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(prod_o) && $stable(exp_o) && $stable(sticky_o)));

  // R3: normalized product has nothing above the integer bit
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((prod_o >> (INT_POS + 1)) == '0));

  // R2: normalized product of valid operands keeps its integer bit
  p_int_bit_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> prod_o[INT_POS]);

endmodule

bind serial_mant_mul smul_chk #(
  .WORD_W(WORD_W), .N_WORDS(N_WORDS), .GUARD(GUARD),
  .INT_POS(INT_POS), .EXP_W(EXP_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done_o(done_o),
  .prod_o(prod_o), .exp_o(exp_o), .sticky_o(sticky_o)
);

// File: tb/tb_serial_mant_mul.sv
module tb_serial_mant_mul;

  localparam int WORD_W  = 32;
  localparam int N_WORDS = 4;
  localparam int GUARD   = 2;
  localparam int INT_POS = 114;
  localparam int EXP_W   = 16;
  localparam int MW      = WORD_W * N_WORDS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [MW-1:0]     mcand_i = '0;
  logic [MW-1:0]     mplier_i = '0;
  logic [EXP_W-1:0]  exp_i = '0;
  logic              done_o;
  logic [MW-1:0]     prod_o;
  logic [EXP_W-1:0]  exp_o;
  logic              sticky_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  serial_mant_mul #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .GUARD(GUARD),
                    .INT_POS(INT_POS), .EXP_W(EXP_W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .exp_i(exp_i), .done_o(done_o), .prod_o(prod_o),
    .exp_o(exp_o), .sticky_o(sticky_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [MW-1:0] ONE  = {{(MW-1){1'b0}}, 1'b1} << INT_POS;
  localparam logic [MW-1:0] MASK = (ONE - 1) & ~(({{(MW-1){1'b0}}, 1'b1} << GUARD) - 1);

  function automatic logic [MW-1:0] mk(input logic [MW-1:0] raw);
    return (raw & MASK) | ONE;
  endfunction

  function automatic int scan_len(input logic [MW-1:0] y);
    int c = 0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (w == N_WORDS - 1)           c += INT_POS - w * WORD_W + 1;
      else if (y[w*WORD_W +: WORD_W] == '0) c += 1;
      else if (w == 0)                c += WORD_W - GUARD;
      else                            c += WORD_W;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [MW-1:0] x, input logic [MW-1:0] y,
                     input logic [EXP_W-1:0] e, input bit poke, input string tag);
    logic [2*MW-1:0]  p;
    logic [MW-1:0]    em;
    logic             es;
    logic [EXP_W-1:0] ee;
    int               n;
    int               first_done;
    p = {{MW{1'b0}}, x} * {{MW{1'b0}}, y};
    if (p[2*INT_POS+1]) begin
      em = MW'(p >> (INT_POS + 1));
      es = |p[INT_POS:0];
      ee = e + 1'b1;
    end else begin
      em = MW'(p >> INT_POS);
      es = |p[INT_POS-1:0];
      ee = e;
    end
    n = scan_len(y) + 1;
    @(negedge clk);
    mcand_i = x; mplier_i = y; exp_i = e; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    first_done = -1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (done_o !== (k == n) && first_done < 0) first_done = k;
      if (poke && k == 3) begin
        start_i = 1'b1; mcand_i = mk(~x); mplier_i = mk(~y); exp_i = ~e;
      end
      if (poke && k == 4) begin
        start_i = 1'b0; mcand_i = x; mplier_i = y; exp_i = e;
      end
    end
    // R4 R5 R6: done rises exactly at the predicted edge, never earlier
    check(first_done < 0, {tag, " R4 done timing"}, MW'(first_done), MW'(n));
    check(prod_o === em, {tag, " R2/R3 mantissa"}, prod_o, em);
    check(sticky_o === es, {tag, " R2/R3 sticky"}, MW'(sticky_o), MW'(es));
    check(exp_o === ee, {tag, " R2/R3 exponent"}, MW'(exp_o), MW'(ee));
    @(negedge clk);
    check(done_o === 1'b0 && prod_o === em && exp_o === ee && sticky_o === es,
          {tag, " R7 pulse and hold"}, prod_o, em);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(done_o === 1'b0, "R1 done", MW'(done_o), '0);
    check(prod_o === '0, "R1 prod", prod_o, '0);
    check(exp_o === '0, "R1 exp", MW'(exp_o), '0);
    check(sticky_o === 1'b0, "R1 sticky", MW'(sticky_o), '0);

    // R2 R5 R6: 1.0 * 1.0, all lower multiplier words zero
    run(ONE, ONE, 16'h0010, 1'b0, "unit");
    // R2: dense operands on every word
    run(mk({32'h0002_4680, 32'h1234_5678, 32'h9abc_def0, 32'h0fed_cba8}),
        mk({32'h0001_1111, 32'h5555_aaaa, 32'h3333_cccc, 32'h7777_8888}),
        16'h1234, 1'b0, "dense");
    // R3 R9: all usable bits set, product just under four
    run(mk('1), mk('1), 16'hffff, 1'b0, "allones");
    // R3: 1.5 * 1.5 = 2.25, exact
    run(ONE | (ONE >> 1), ONE | (ONE >> 1), 16'h0100, 1'b0, "onehalf");
    // R6: middle word zero, lowest word nonzero
    run(mk({32'h0003_0303, 32'hfeed_f00d, 32'h0bad_cafe, 32'h1111_2224}),
        mk({32'h0001_2345, 32'h89ab_cdef, 32'h0000_0000, 32'h1357_9bdc}),
        16'h0042, 1'b0, "midzero");
    // R5 R6: lowest word only, sticky from dropped low bits
    run(mk({32'h0000_0001, 32'h0, 32'h0, 32'h0000_0007}),
        mk({32'h0, 32'h0, 32'h0, 32'h8000_0004}),
        16'h7fff, 1'b0, "lowonly");
    // R8: start pulse with other operands while busy
    run(mk({32'h0002_4680, 32'h1234_5678, 32'h9abc_def0, 32'h0fed_cba8}),
        mk({32'h0001_1111, 32'h5555_aaaa, 32'h3333_cccc, 32'h7777_8888}),
        16'h0abc, 1'b1, "R8 busystart");
    // R8: ignored start while lower words are being skipped
    run(ONE | (ONE >> 3), ONE, 16'h0001, 1'b1, "R8 skipstart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule